// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and the lower memory level. It accepts processor stores through a ready/valid handshake, so the processor carries on without waiting for memory. Buffered stores are grouped by block: a store whose block is already held is folded into that entry, one word slot at a time, and each entry keeps a mask of which word slots it has written. Entries leave for memory in the order they were allocated. Each one goes out as a single block-wide write whose word enables are the entry's mask.

Reads come first on the memory port. While a read is presented and does not touch buffered data, no new drain is started. Every read address is compared against the buffered blocks. If the word is buffered, its newest value is forwarded. If the block is buffered but that word is not, the block flags that draining is needed first. Draining then proceeds even while the read is held.

Top module: `store_merge_buf`

## Requirements
- R1: After reset the buffer is empty: `st_ready` is 1, `mem_valid` is 0, and a read reports no hit.
- R2: A store whose block address (store address without its low log2(WORDS) word-index bits) matches an occupied entry updates that entry and allocates nothing. The later block-wide write carries every merged word.
- R3: A store to a block not held allocates a new entry. With all ENTRIES entries occupied, a store matching none of them sees `st_ready` low, while a store matching a held entry is still accepted.
- R4: Entries drain to memory in allocation order, one entry per accepted transfer (`mem_valid` and `mem_ready` both high at a clock edge).
- R5: Once `mem_valid` is raised, it and `mem_blk_addr`, `mem_data` and `mem_wmask` stay unchanged until the transfer is accepted.
- R6: A drain starts one cycle after a cycle in which the buffer is non-empty, idle on the memory port and either has no read presented or has a read that needs a drain. While a read without that need is presented, no drain starts.
- R7: A read whose word is held in a buffered entry gives `rd_fwd_valid` = 1 and `rd_data` equal to the last value stored to that word.
- R8: A read whose block is buffered but whose word slot is unwritten gives `rd_need_drain` = 1 and `rd_fwd_valid` = 0.
- R9: A store matching the entry currently being drained is stalled (`st_ready` low) until that transfer completes. After that it allocates a fresh entry.
- R10: `mem_wmask` bit k is 1 exactly for the word slots k written since the entry was allocated, and `mem_data` word k (bits k*DATA_W upward) holds the last value stored there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data word |
| rd_valid | input | 1 | Read address presented for checking |
| rd_addr | input | ADDR_W | Read word address |
| rd_hit | output | 1 | Read block is held in the buffer |
| rd_fwd_valid | output | 1 | `rd_data` carries the buffered word |
| rd_data | output | DATA_W | Forwarded word |
| rd_need_drain | output | 1 | Read must wait for draining |
| mem_valid | output | 1 | Block write offered to memory |
| mem_ready | input | 1 | Memory takes the block write |
| mem_blk_addr | output | ADDR_W-log2(WORDS) | Block address of the write |
| mem_data | output | WORDS*DATA_W | Block data, word 0 in the low bits |
| mem_wmask | output | WORDS | Per-word write enables |

## Verification
A store can merge into, or allocate, an entry in the same cycle that the memory accepts the oldest entry. A read check can also fall in the cycle where a drain would launch. The bench provokes both with random store, read and memory-ready traffic over a small pool of block addresses, so that merges, full stalls, hits on the draining entry and conflicting reads collide often. A cycle-accurate bench model of the queue judges `st_ready`, the memory write fields and the read results in every cycle.

// File: rtl/smb_pkg.sv
package smb_pkg;
    typedef enum logic {
        DRN_IDLE = 1'b0,
        DRN_BUSY = 1'b1
    } drn_e;
endpackage

// File: rtl/smb_blk_cam.sv
// Compares a block key against every occupied entry; returns hit and index.
module smb_blk_cam #(
    parameter int ENTRIES = 4,
    parameter int BLK_W   = 14,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            occ,
    input  logic [ENTRIES-1:0][BLK_W-1:0] tags,
    input  logic [BLK_W-1:0]              key,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);
    logic [ENTRIES-1:0] eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign eq[g] = occ[g] && (tags[g] == key);
    end

    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/smb_rd_fwd.sv
// Resolves a read check into forward / drain-needed outcomes.
module smb_rd_fwd #(
    parameter int DATA_W = 32
) (
    input  logic              rd_valid,
    input  logic              blk_hit,
    input  logic              word_set,
    input  logic [DATA_W-1:0] word_val,
    output logic              rd_hit,
    output logic              rd_fwd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_need_drain
);
    always_comb begin
        rd_hit        = rd_valid && blk_hit;
        rd_fwd_valid  = rd_hit && word_set;
        rd_need_drain = rd_hit && !word_set;
        rd_data       = rd_fwd_valid ? word_val : '0;
    end
endmodule

// File: rtl/store_merge_buf.sv
module store_merge_buf
    import smb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 16,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int BLK_W  = ADDR_W - OFF_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [ADDR_W-1:0]       st_addr,
    input  logic [DATA_W-1:0]       st_data,
    input  logic                    rd_valid,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic                    rd_hit,
    output logic                    rd_fwd_valid,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    rd_need_drain,
    output logic                    mem_valid,
    input  logic                    mem_ready,
    output logic [BLK_W-1:0]        mem_blk_addr,
    output logic [WORDS*DATA_W-1:0] mem_data,
    output logic [WORDS-1:0]        mem_wmask
);
    typedef struct packed {
        logic [ENTRIES-1:0]                         occ;
        logic [ENTRIES-1:0][BLK_W-1:0]              blk;
        logic [ENTRIES-1:0][WORDS-1:0][DATA_W-1:0]  dat;
        logic [ENTRIES-1:0][WORDS-1:0]              msk;
        logic [IDX_W-1:0]                           head;
        logic [IDX_W-1:0]                           tail;
        drn_e                                       drn;
    } state_t;

    state_t s_q, s_d;

    logic [BLK_W-1:0] st_blk, rd_blk;
    logic [OFF_W-1:0] st_word, rd_word;
    logic             st_hit, rd_blk_hit;
    logic [IDX_W-1:0] st_idx, rd_idx;
    logic             st_fire, pop;

    assign st_blk  = st_addr[ADDR_W-1:OFF_W];
    assign st_word = st_addr[OFF_W-1:0];
    assign rd_blk  = rd_addr[ADDR_W-1:OFF_W];
    assign rd_word = rd_addr[OFF_W-1:0];

    smb_blk_cam #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) u_st_cam (
        .occ(s_q.occ), .tags(s_q.blk), .key(st_blk),
        .hit(st_hit), .idx(st_idx)
    );

    smb_blk_cam #(.ENTRIES(ENTRIES), .BLK_W(BLK_W)) u_rd_cam (
        .occ(s_q.occ), .tags(s_q.blk), .key(rd_blk),
        .hit(rd_blk_hit), .idx(rd_idx)
    );

    smb_rd_fwd #(.DATA_W(DATA_W)) u_rd_fwd (
        .rd_valid(rd_valid),
        .blk_hit(rd_blk_hit),
        .word_set(s_q.msk[rd_idx][rd_word]),
        .word_val(s_q.dat[rd_idx][rd_word]),
        .rd_hit(rd_hit),
        .rd_fwd_valid(rd_fwd_valid),
        .rd_data(rd_data),
        .rd_need_drain(rd_need_drain)
    );

    // A matching store waits only when its entry is on the memory port.
    always_comb begin
        if (st_hit) st_ready = !((st_idx == s_q.head) && (s_q.drn == DRN_BUSY));
        else        st_ready = !(&s_q.occ);
    end

    assign mem_valid    = (s_q.drn == DRN_BUSY);
    assign mem_blk_addr = s_q.blk[s_q.head];
    assign mem_data     = s_q.dat[s_q.head];
    assign mem_wmask    = s_q.msk[s_q.head];

    always_comb begin
        s_d     = s_q;
        st_fire = st_valid && st_ready;
        pop     = (s_q.drn == DRN_BUSY) && mem_ready;

        if (st_fire) begin
            if (st_hit) begin
                s_d.dat[st_idx][st_word] = st_data;
                s_d.msk[st_idx][st_word] = 1'b1;
            end else begin
                s_d.occ[s_q.tail]          = 1'b1;
                s_d.blk[s_q.tail]          = st_blk;
                s_d.msk[s_q.tail]          = '0;
                s_d.msk[s_q.tail][st_word] = 1'b1;
                s_d.dat[s_q.tail][st_word] = st_data;
                s_d.tail                   = s_q.tail + 1'b1;
            end
        end

        if (pop) begin
            s_d.occ[s_q.head] = 1'b0;
            s_d.head          = s_q.head + 1'b1;
            s_d.drn           = DRN_IDLE;
        end else if ((s_q.drn == DRN_IDLE) && (|s_q.occ)
                     && (!rd_valid || rd_need_drain)) begin
            s_d.drn = DRN_BUSY;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/store_merge_buf_chk.sv
module store_merge_buf_chk #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int BLK_W  = 14
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    rd_valid,
    input logic                    rd_hit,
    input logic                    rd_fwd_valid,
    input logic                    rd_need_drain,
    input logic                    mem_valid,
    input logic                    mem_ready,
    input logic [BLK_W-1:0]        mem_blk_addr,
    input logic [WORDS*DATA_W-1:0] mem_data,
    input logic [WORDS-1:0]        mem_wmask
);
    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_blk_addr)
        && $stable(mem_wmask) && $stable(mem_data)); // R5

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid && rd_valid && !rd_need_drain |=> !mem_valid); // R6

    AST_FWD_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fwd_valid |-> rd_hit && rd_valid); // R7

    AST_HIT_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (rd_fwd_valid != rd_need_drain)); // R8

    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_wmask != '0); // R10
endmodule

bind store_merge_buf store_merge_buf_chk #(
    .WORDS(WORDS), .DATA_W(DATA_W), .BLK_W(BLK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_hit(rd_hit),
    .rd_fwd_valid(rd_fwd_valid), .rd_need_drain(rd_need_drain),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_blk_addr(mem_blk_addr),
    .mem_data(mem_data), .mem_wmask(mem_wmask)
);

// File: tb/store_merge_buf_tb.sv
module store_merge_buf_tb;
    localparam int PERIOD  = 10;
    localparam int ENTRIES = 4;
    localparam int WORDS   = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 16;
    localparam int BLK_W   = ADDR_W - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0, rd_valid = 1'b0, mem_ready = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0, rd_addr = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic st_ready, rd_hit, rd_fwd_valid, rd_need_drain, mem_valid;
    logic [DATA_W-1:0] rd_data;
    logic [BLK_W-1:0] mem_blk_addr;
    logic [WORDS*DATA_W-1:0] mem_data;
    logic [WORDS-1:0] mem_wmask;

    int checks = 0, failures = 0;
    bit done = 0;

    // queue model: index 0 is the oldest entry
    int mcnt;
    bit mdq;
    logic [BLK_W-1:0]  mblk [ENTRIES];
    logic [DATA_W-1:0] mdat [ENTRIES][WORDS];
    logic [WORDS-1:0]  mmsk [ENTRIES];

    store_merge_buf u_dut (.*);

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int find_blk(input logic [BLK_W-1:0] b);
        int r = -1;
        for (int i = 0; i < mcnt; i++) if (mblk[i] == b) r = i;
        return r;
    endfunction

    // Check outputs against the model, then advance the model over the edge.
    task automatic step_check();
        int m, rm, pre;
        bit exp_rdy, hit, fwd, need;
        int w, rw;
        m = find_blk(st_addr[ADDR_W-1:2]);
        w = int'(st_addr[1:0]);
        exp_rdy = (m >= 0) ? !(m == 0 && mdq) : (mcnt < ENTRIES);
        chk("R3 R9 st_ready", st_ready, exp_rdy);
        chk("R5 R6 mem_valid", mem_valid, mdq);
        if (mdq) begin
            chk("R4 mem_blk_addr", mem_blk_addr, mblk[0]);
            chk("R10 mem_wmask", mem_wmask, mmsk[0]);
            for (int k = 0; k < WORDS; k++)
                if (mmsk[0][k]) chk("R2 mem_data", mem_data[k*DATA_W +: DATA_W], mdat[0][k]);
        end
        need = 0;
        if (rd_valid) begin
            rm  = find_blk(rd_addr[ADDR_W-1:2]);
            rw  = int'(rd_addr[1:0]);
            hit = (rm >= 0);
            fwd = hit && mmsk[rm][rw];
            need = hit && !fwd;
            chk("R7 rd_hit", rd_hit, hit);
            chk("R7 rd_fwd_valid", rd_fwd_valid, fwd);
            chk("R8 rd_need_drain", rd_need_drain, need);
            if (fwd) chk("R7 rd_data", rd_data, mdat[rm][rw]);
        end
        pre = mcnt;
        if (st_valid && exp_rdy) begin
            if (m >= 0) begin
                mdat[m][w] = st_data; mmsk[m][w] = 1'b1;
            end else begin
                mblk[mcnt] = st_addr[ADDR_W-1:2];
                mmsk[mcnt] = '0; mmsk[mcnt][w] = 1'b1; mdat[mcnt][w] = st_data;
                mcnt++;
            end
        end
        if (mdq && mem_ready) begin
            for (int i = 0; i < ENTRIES-1; i++) begin
                mblk[i] = mblk[i+1]; mmsk[i] = mmsk[i+1];
                for (int k = 0; k < WORDS; k++) mdat[i][k] = mdat[i+1][k];
            end
            mcnt--;
            mdq = 0;
        end else if (!mdq && pre > 0 && (!rd_valid || need)) begin
            mdq = 1;
        end
    endtask

    task automatic cyc(input bit sv, input int sa, input logic [DATA_W-1:0] sd,
                       input bit rv, input int ra, input bit mr);
        @(negedge clk);
        st_valid = sv; st_addr = ADDR_W'(sa); st_data = sd;
        rd_valid = rv; rd_addr = ADDR_W'(ra); mem_ready = mr;
        #(PERIOD/4);
        step_check();
    endtask

    initial begin
        int sa, ra;
        bit sv, hold;
        logic [DATA_W-1:0] sd;
        void'($urandom(32'h5eed_0042));
        mcnt = 0; mdq = 0;
        for (int i = 0; i < ENTRIES; i++) mmsk[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #(PERIOD/4);
        chk("R1 st_ready", st_ready, 1'b1);
        chk("R1 mem_valid", mem_valid, 1'b0);
        rd_valid = 1'b1; rd_addr = 16'h0005; #1;
        chk("R1 rd_hit", rd_hit, 1'b0);

        // Directed: reads to an unrelated block hold drains off (R6).
        cyc(1, 16'h0010, 32'hA0, 1, 16'h0400, 0); // blk 4 word 0
        cyc(1, 16'h0021, 32'hB1, 1, 16'h0400, 0); // blk 8
        cyc(1, 16'h0032, 32'hC2, 1, 16'h0400, 0); // blk 12
        cyc(1, 16'h0043, 32'hD3, 1, 16'h0400, 0); // blk 16, buffer full
        cyc(1, 16'h0050, 32'hE0, 1, 16'h0400, 0); // R3: new block stalls
        cyc(1, 16'h0012, 32'hA2, 1, 16'h0400, 0); // R2: merge while full
        cyc(1, 16'h0012, 32'hA9, 1, 16'h0012, 0); // R10: overwrite; R7 fwd old
        cyc(0, 0, 0, 1, 16'h0012, 0);             // R7: newest value
        cyc(0, 0, 0, 1, 16'h0011, 0);             // R8: need drain, launch
        cyc(1, 16'h0013, 32'hA3, 1, 16'h0011, 0); // R9: draining entry stalls
        cyc(1, 16'h0013, 32'hA3, 0, 0, 1);        // R4: oldest leaves
        cyc(1, 16'h0013, 32'hA3, 0, 0, 0);        // R9: reallocates
        repeat (12) cyc(0, 0, 0, 0, 0, 1);        // R4: empty out

        // Random phase over a small block pool.
        hold = 0; sa = 0; sd = '0;
        for (int n = 0; n < 4000; n++) begin
            if (!hold) begin
                sv = ($urandom % 3) != 0;
                sa = int'(($urandom % 6) * 4 + ($urandom % 4));
                sd = $urandom;
            end
            ra = int'(($urandom % 6) * 4 + ($urandom % 4));
            cyc(sv, sa, sd, ($urandom % 2) == 1, ra, ($urandom % 3) == 0);
            hold = sv && !st_ready;
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule